// File: doc/BRIEF.md
# Code-Region Memory Privilege Controller

This block guards two protected memory areas, a system area and a loader area. It holds a four-bit privilege word with separate read and write enables for each area. A companion mask word lets software change privileges through a masked two-step write. The block watches which code region is executing. Privileges granted to trusted regions disappear as soon as execution moves to less trusted code, and only trusted code can set privileges again.

Each data access request comes with its target area and direction. The block grants the request at once or blocks it. A blocked request takes no effect and produces a one-cycle protection-fault pulse in the next cycle. Both registers are readable from any region.

The controller is a two-state machine. `ST_OPEN` is the normal state. `ST_FAULT` is held for one cycle after each blocked access. There are three transitions. *open-to-fault* is taken on a blocked access. *fault-to-fault* is taken when another blocked access arrives while in `ST_FAULT`. *fault-to-open* is taken otherwise.

Top module: `priv_guard_top`

## Requirements
- R1: `priv_rd[3:0]` holds loader-read (bit 0), loader-write (bit 1), system-read (bit 2) and system-write (bit 3). `mask_rd[3:0]` holds the mask. Bits 7..4 of both readbacks are always 0.
- R2: Reset loads the privilege word with 4'hF and the mask with 4'h0.
- R3: While `exec_region` is neither utility ROM (2'b01) nor system (2'b10), bits 3 and 2 of both readbacks are 0 in that same cycle, and the stored bits are cleared at the next edge.
- R4: While `exec_region` is "other" (2'b00), bits 1 and 0 of both readbacks are 0, and the stored bits are cleared at the next edge.
- R5: A register write (`reg_wr_en`=1) may change bits 3..2 only from utility ROM or system code, and bits 1..0 from those regions or loader code (2'b11). Bits the region may not change keep their value, and the attempt raises no fault. `reg_wr_sel` 2'b00 selects the privilege word, 2'b01 selects the mask, 2'b10 selects the masked commit, and 2'b11 writes nothing.
- R6: Any write to the privilege word (sel 2'b00) or a masked commit (sel 2'b10) leaves the mask at 0 after that edge.
- R7: A masked commit stores `reg_wr_data[3:0]` AND mask into the permitted privilege bits.
- R8: `mem_grant` equals `mem_req` except when the request is blocked. A request is blocked when it reads the system area (`mem_area`=2'b01, `mem_we`=0) with bit 2 at 0, writes it with bit 3 at 0, reads the loader area (2'b10) with bit 0 at 0, or writes it with bit 1 at 0. Areas 2'b00 and 2'b11 are never blocked.
- R9: `fault_irq` is 1 for exactly the cycle after each blocked request and 0 otherwise.
- R10: When an automatic clear and a register write hit the same bit in the same cycle, the bit ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| exec_region | input | 2 | Region of current instruction: 00 other, 01 utility ROM, 10 system, 11 loader |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Write target: 00 privilege, 01 mask, 10 masked commit, 11 none |
| reg_wr_data | input | 8 | Write data |
| mem_req | input | 1 | Data access request |
| mem_we | input | 1 | 1 = write access, 0 = read |
| mem_area | input | 2 | Target area: 01 system, 10 loader, 00/11 unprotected |
| mem_grant | output | 1 | Access may proceed |
| fault_irq | output | 1 | Protection-fault pulse |
| priv_rd | output | 8 | Privilege word readback |
| mask_rd | output | 8 | Mask word readback |

## Verification
The bench targets writes issued from loader or untrusted code. A design that lets the region widen its own rights would set system bits from loader code. The bench also holds a write and a region exit in the same cycle. A design that lets the write win would leave a stale privilege set after leaving trusted code. It checks the masked commit with mask bits both set and clear, and checks that the mask is gone after a commit or a privilege write. A design that kept the mask would allow a second commit to reuse it. Back-to-back blocked accesses check that the fault is exactly one cycle per block. An off-by-one in the state machine would stretch the pulse or drop it.

// File: rtl/priv_guard_pkg.sv
package priv_guard_pkg;
    localparam int PRIV_W = 4;

    typedef enum logic [1:0] {
        RGN_OTHER = 2'b00,
        RGN_UROM  = 2'b01,
        RGN_SYS   = 2'b10,
        RGN_LDR   = 2'b11
    } region_e;

    typedef enum logic [1:0] {
        SEL_PRIV   = 2'b00,
        SEL_MASK   = 2'b01,
        SEL_COMMIT = 2'b10,
        SEL_NONE   = 2'b11
    } wsel_e;

    typedef enum logic [1:0] {
        AREA_OPEN0 = 2'b00,
        AREA_SYS   = 2'b01,
        AREA_LDR   = 2'b10,
        AREA_OPEN3 = 2'b11
    } area_e;

    typedef enum logic {
        ST_OPEN  = 1'b0,
        ST_FAULT = 1'b1
    } guard_st_e;

    // Bits a region may hold and modify (identical sets for both purposes).
    function automatic logic [PRIV_W-1:0] region_rights(region_e r);
        unique case (r)
            RGN_UROM, RGN_SYS: return 4'hF;
            RGN_LDR:           return 4'h3;
            default:           return 4'h0;
        endcase
    endfunction
endpackage

// File: rtl/priv_regs.sv
module priv_regs
    import priv_guard_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [PRIV_W-1:0] PRIV_RST = 4'hF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PRIV_W-1:0] rights,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [PRIV_W-1:0] priv_eff,
    output logic [PRIV_W-1:0] mask_eff
);
    logic [PRIV_W-1:0] priv_q, mask_q;
    logic [PRIV_W-1:0] priv_upd, mask_upd;
    logic [PRIV_W-1:0] wdat;

    assign wdat = wr_data[PRIV_W-1:0];

    always_comb begin
        priv_upd = priv_q;
        mask_upd = mask_q;
        if (wr_en) begin
            unique case (wsel_e'(wr_sel))
                SEL_PRIV: begin
                    priv_upd = (priv_q & ~rights) | (wdat & rights);
                    mask_upd = '0;
                end
                SEL_MASK: begin
                    mask_upd = (mask_q & ~rights) | (wdat & rights);
                end
                SEL_COMMIT: begin
                    priv_upd = (priv_q & ~rights) | (wdat & mask_q & rights);
                    mask_upd = '0;
                end
                default: ;
            endcase
        end
    end

    // Automatic clearing is applied last so it overrides any write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            priv_q <= PRIV_RST;
            mask_q <= '0;
        end else begin
            priv_q <= priv_upd & rights;
            mask_q <= mask_upd & rights;
        end
    end

    assign priv_eff = priv_q & rights;
    assign mask_eff = mask_q & rights;
endmodule

// File: rtl/priv_access_fsm.sv
module priv_access_fsm
    import priv_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PRIV_W-1:0] priv_eff,
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic [1:0]        mem_area,
    output logic              mem_grant,
    output logic              fault_irq
);
    guard_st_e st_q, st_d;
    logic      needed, blocked;

    always_comb begin
        unique case (area_e'(mem_area))
            AREA_SYS: needed = mem_we ? priv_eff[3] : priv_eff[2];
            AREA_LDR: needed = mem_we ? priv_eff[1] : priv_eff[0];
            default:  needed = 1'b1;
        endcase
        blocked = mem_req && !needed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OPEN;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            ST_OPEN:  st_d = blocked ? ST_FAULT : ST_OPEN;
            ST_FAULT: st_d = blocked ? ST_FAULT : ST_OPEN;
            default:  st_d = ST_OPEN;
        endcase
    end

    always_comb begin
        mem_grant = mem_req && !blocked;
        fault_irq = (st_q == ST_FAULT);
    end
endmodule

// File: rtl/priv_guard_top.sv
module priv_guard_top
    import priv_guard_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        exec_region,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_wr_sel,
    input  logic [DATA_W-1:0] reg_wr_data,
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic [1:0]        mem_area,
    output logic              mem_grant,
    output logic              fault_irq,
    output logic [DATA_W-1:0] priv_rd,
    output logic [DATA_W-1:0] mask_rd
);
    localparam int PAD_W = DATA_W - PRIV_W;

    logic [PRIV_W-1:0] rights;
    logic [PRIV_W-1:0] priv_eff, mask_eff;

    assign rights = region_rights(region_e'(exec_region));

    priv_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .rights   (rights),
        .wr_en    (reg_wr_en),
        .wr_sel   (reg_wr_sel),
        .wr_data  (reg_wr_data),
        .priv_eff (priv_eff),
        .mask_eff (mask_eff)
    );

    priv_access_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .priv_eff  (priv_eff),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_area  (mem_area),
        .mem_grant (mem_grant),
        .fault_irq (fault_irq)
    );

    assign priv_rd = {{PAD_W{1'b0}}, priv_eff};
    assign mask_rd = {{PAD_W{1'b0}}, mask_eff};
endmodule

// File: rtl/priv_guard_chk.sv
module priv_guard_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        exec_region,
    input logic              reg_wr_en,
    input logic [1:0]        reg_wr_sel,
    input logic              mem_req,
    input logic              mem_we,
    input logic [1:0]        mem_area,
    input logic              mem_grant,
    input logic              fault_irq,
    input logic [DATA_W-1:0] priv_rd,
    input logic [DATA_W-1:0] mask_rd
);
    logic blocked_seen;
    assign blocked_seen = mem_req && !mem_grant;

    p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_rd[DATA_W-1:4] == '0) && (mask_rd[DATA_W-1:4] == '0));

    p_sys_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_region != 2'b01 && exec_region != 2'b10) |->
            (priv_rd[3:2] == 2'b00 && mask_rd[3:2] == 2'b00));

    p_ldr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_region == 2'b00) |-> (priv_rd[1:0] == 2'b00 && mask_rd[1:0] == 2'b00));

    p_mask_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && (reg_wr_sel == 2'b00 || reg_wr_sel == 2'b10)) |=> (mask_rd == '0));

    p_sys_read_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_area == 2'b01 && !mem_we && !priv_rd[2]) |-> !mem_grant);

    p_open_area_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && (mem_area == 2'b00 || mem_area == 2'b11)) |-> mem_grant);

    p_fault_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        blocked_seen |=> fault_irq);

    p_fault_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !blocked_seen |=> !fault_irq);
endmodule

bind priv_guard_top priv_guard_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .exec_region (exec_region),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_sel  (reg_wr_sel),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_area    (mem_area),
    .mem_grant   (mem_grant),
    .fault_irq   (fault_irq),
    .priv_rd     (priv_rd),
    .mask_rd     (mask_rd)
);

// File: tb/test_priv_guard_top.sv
module test_priv_guard_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] exec_region = 2'b01;
    logic       reg_wr_en = 1'b0;
    logic [1:0] reg_wr_sel = 2'b11;
    logic [7:0] reg_wr_data = 8'h00;
    logic       mem_req = 1'b0;
    logic       mem_we = 1'b0;
    logic [1:0] mem_area = 2'b00;
    logic       mem_grant, fault_irq;
    logic [7:0] priv_rd, mask_rd;

    int n_tests = 0;
    int n_fail  = 0;

    logic [3:0] m_priv = 4'hF;
    logic [3:0] m_mask = 4'h0;
    logic       m_fault = 1'b0;

    always #10 clk = ~clk;

    priv_guard_top i_priv_guard_top (
        .clk(clk), .rst_n(rst_n), .exec_region(exec_region),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_area(mem_area),
        .mem_grant(mem_grant), .fault_irq(fault_irq),
        .priv_rd(priv_rd), .mask_rd(mask_rd)
    );

    function automatic logic [3:0] rights_of(logic [1:0] r);
        if (r == 2'b01 || r == 2'b10) return 4'hF;
        if (r == 2'b11) return 4'h3;
        return 4'h0;
    endfunction

    function automatic logic exp_grant(logic req, logic we, logic [1:0] area, logic [3:0] p);
        if (!req) return 1'b0;
        if (area == 2'b01) return we ? p[3] : p[2];
        if (area == 2'b10) return we ? p[1] : p[0];
        return 1'b1;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drives one cycle: set inputs, compare outputs, then advance the model.
    task automatic step(logic [1:0] rg, logic we_r, logic [1:0] sel, logic [7:0] d,
                        logic rq, logic wm, logic [1:0] ar);
        logic [3:0] rt, pe, pu, mu;
        exec_region = rg; reg_wr_en = we_r; reg_wr_sel = sel; reg_wr_data = d;
        mem_req = rq; mem_we = wm; mem_area = ar;
        #5;
        rt = rights_of(rg);
        pe = m_priv & rt;
        // R1 R3 R4: readback shows only bits the region may hold, upper nibble zero
        check("R1 R3 R4 priv_rd", priv_rd, {4'h0, pe});
        check("R1 R3 R4 mask_rd", mask_rd, {4'h0, m_mask & rt});
        // R8: grant decision
        check("R8 mem_grant", mem_grant, exp_grant(rq, wm, ar, pe));
        // R9: fault pulse one cycle after a block
        check("R9 fault_irq", fault_irq, m_fault);
        @(posedge clk);
        m_fault = rq && !exp_grant(rq, wm, ar, pe);
        pu = m_priv; mu = m_mask;
        if (we_r) begin
            case (sel)
                2'b00: begin pu = (m_priv & ~rt) | (d[3:0] & rt); mu = 4'h0; end  // R5 R6
                2'b01: mu = (m_mask & ~rt) | (d[3:0] & rt);                         // R5
                2'b10: begin pu = (m_priv & ~rt) | (d[3:0] & m_mask & rt); mu = 4'h0; end // R7
                default: ;
            endcase
        end
        m_priv = pu & rt;   // R10: clearing wins
        m_mask = mu & rt;
        @(negedge clk);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd1234);
        #35;
        // R2: reset state, viewed from utility ROM
        check("R2 priv reset", priv_rd, 8'h0F);
        check("R2 mask reset", mask_rd, 8'h00);
        check("R2 fault reset", fault_irq, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: loader code cannot raise system bits; first clear them from system
        step(2'b10, 1, 2'b00, 8'h03, 0, 0, 2'b00);
        step(2'b11, 1, 2'b00, 8'hFF, 0, 0, 2'b00);
        check("R5 loader write keeps sys bits", priv_rd, 8'h03);
        // R8 R9: blocked system read, then back-to-back blocks
        step(2'b10, 0, 2'b11, 8'h00, 1, 0, 2'b01);
        step(2'b10, 0, 2'b11, 8'h00, 1, 1, 2'b01);
        step(2'b10, 0, 2'b11, 8'h00, 0, 0, 2'b00);
        step(2'b10, 0, 2'b11, 8'h00, 0, 0, 2'b00);
        // R7 R6: masked commit from system code
        step(2'b10, 1, 2'b01, 8'h0A, 0, 0, 2'b00);
        step(2'b10, 1, 2'b10, 8'h0E, 0, 0, 2'b00);
        check("R7 commit result", priv_rd, 8'h0A);
        check("R6 mask cleared after commit", mask_rd, 8'h00);
        // R10: write of all ones while region is other
        step(2'b00, 1, 2'b00, 8'h0F, 0, 0, 2'b00);
        step(2'b01, 0, 2'b11, 8'h00, 0, 0, 2'b00);
        check("R10 clear beats write", priv_rd, 8'h00);
        // R5: write attempt from other region raises no fault
        step(2'b00, 1, 2'b01, 8'h0F, 0, 0, 2'b00);
        step(2'b01, 0, 2'b11, 8'h00, 0, 0, 2'b00);
        check("R5 no fault on denied write", fault_irq, 1'b0);
        check("R5 mask unchanged", mask_rd, 8'h00);
        // Restore full rights then random mix
        step(2'b01, 1, 2'b00, 8'h0F, 0, 0, 2'b00);
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] rg;
            rg = ($urandom_range(0, 9) < 7) ? 2'($urandom_range(1, 3)) : 2'b00;
            step(rg, 1'($urandom_range(0, 1)), 2'($urandom), 8'($urandom),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 2'($urandom));
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule